// File: doc/BRIEF.md
# Convolutional Byte De-Interleaver

This block reverses a convolutional (Forney) interleave applied to a framed byte stream. It sits between a packet framer and a block error decoder. The framer supplies bytes with a valid strobe and a pulse on the first byte of each packet. The block returns the bytes in their original order, with a valid strobe and a packet-start pulse that is realigned to the restored stream.

The number of branches and the delay step per branch are chosen at run time from four legal pairs. In every pair, branches times step equals the packet length. Branch k holds its bytes for (branches-1-k) times step visits. All branches share one RAM, which is split into circular regions sized for the largest setting. The first branch has the longest region and the last branch bypasses the RAM.

A load pulse selects a new setting. The load clears every branch pointer, drops alignment and restarts the fill count. Until a packet-start has been seen, incoming bytes are ignored. The restored stream runs branches × step × (branches-1) bytes behind the input, and output is withheld until that many bytes have been accepted.

Top module: `conv_deinterleaver`

## Requirements
- R1: After reset, o_valid and o_start are low, and setting 0 is selected.
- R2: The value on i_cfg_sel at a load selects (branches, step) as 0:(4,51), 1:(6,34), 2:(17,6), 3:(12,17). The packet length is branches × step, which is 204, 204, 102 and 204.
- R3: After reset or a load, bytes that arrive before the first byte flagged with i_start are discarded and give no output.
- R4: Count accepted bytes as t = 0, 1, 2, ... from the aligning packet-start. For t ≥ L, where L = branches × step × (branches-1) (612, 1020, 1632 and 2244), o_data carries the byte that had original stream index t-L.
- R5: For the first L accepted bytes after alignment, o_valid stays low. After that, o_valid is high in the cycle that follows each accepted byte.
- R6: A cycle with i_valid low does not advance the stream, and o_valid is low in the next cycle.
- R7: o_start is high exactly when o_valid is high and the matching input byte carried i_start. That happens on every output byte whose original index is a multiple of the packet length.
- R8: A load flushes the branches. Pointers restart, and after the next packet-start no valid output appears before a new full latency, whatever data was stored before.
- R9: An i_start that arrives mid-stream sends the byte down branch 0 and restarts the branch rotation from there. From L bytes after that start, the output carries the realigned stream.
- R10: A load takes priority over a byte presented in the same cycle, and that byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_cfg_load | input | 1 | Load a new setting and flush the branches |
| i_cfg_sel | input | 2 | Setting index used at a load |
| i_valid | input | 1 | Input byte valid |
| i_start | input | 1 | Input byte is the first byte of a packet |
| i_data | input | 8 | Interleaved input byte |
| o_valid | output | 1 | Restored byte valid |
| o_start | output | 1 | Restored byte is the first byte of a packet |
| o_data | output | 8 | Restored byte |

## Verification
The bench builds the block with its default sizing: a 1122-byte RAM, 17 pointer slots and a 12-bit fill counter. This lets all four legal settings run end to end, including the largest storage case of 12 branches with a step of 17. For each setting, the bench computes the interleaved stream in closed form and feeds it with periodic idle cycles. It then compares every output byte across the full fill and two further packets. Junk before alignment, a load that coincides with a byte, and a mid-stream realignment after off-phase bytes are each checked at the outputs.

// File: rtl/dil_pkg.sv
package dil_pkg;

    typedef struct packed {
        logic [4:0] depth;
        logic [5:0] incr;
    } dil_cfg_t;

    // Legal (branches, step) pairs; branches * step equals the packet length.
    function automatic dil_cfg_t dil_lookup(input logic [1:0] sel);
        dil_cfg_t c;
        unique case (sel)
            2'd0:    begin c.depth = 5'd4;  c.incr = 6'd51; end
            2'd1:    begin c.depth = 5'd6;  c.incr = 6'd34; end
            2'd2:    begin c.depth = 5'd17; c.incr = 6'd6;  end
            default: begin c.depth = 5'd12; c.incr = 6'd17; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dil_cfg_decode.sv
module dil_cfg_decode
    import dil_pkg::*;
#(
    parameter int DEPTH_W = 5,
    parameter int INCR_W  = 6,
    parameter int CNT_W   = 12
) (
    input  logic [1:0]         sel,
    output logic [DEPTH_W-1:0] depth,
    output logic [INCR_W-1:0]  incr,
    output logic [CNT_W-1:0]   latency
);
    dil_cfg_t c;

    always_comb begin
        c       = dil_lookup(sel);
        depth   = DEPTH_W'(c.depth);
        incr    = INCR_W'(c.incr);
        latency = CNT_W'(16'(c.depth) * 16'(c.incr) * (16'(c.depth) - 16'd1));
    end
endmodule

// File: rtl/dil_branch_addr.sv
module dil_branch_addr #(
    parameter int DEPTH_W = 5,
    parameter int INCR_W  = 6,
    parameter int PTR_W   = 8,
    parameter int AW      = 11
) (
    input  logic [DEPTH_W-1:0] depth,
    input  logic [INCR_W-1:0]  incr,
    input  logic [DEPTH_W-1:0] branch,
    input  logic [PTR_W-1:0]   ptr,
    output logic [AW-1:0]      addr,
    output logic [PTR_W-1:0]   len
);
    logic [15:0] rem;
    logic [15:0] br;
    logic [15:0] base;

    always_comb begin
        br   = 16'(branch);
        rem  = 16'(depth) - 16'd1 - br;
        len  = PTR_W'(rem * 16'(incr));
        // Region start: step times the sum of the lengths of earlier branches.
        base = 16'(incr) * (br * (16'(depth) - 16'd1) - ((br * (br - 16'd1)) >> 1));
        addr = AW'(base + 16'(ptr));
    end
endmodule

// File: rtl/dil_ram.sv
module dil_ram #(
    parameter int WORDS = 1122,
    parameter int AW    = 11,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [WORDS];

    // Read returns the old word while the new byte is written.
    always_ff @(posedge clk) begin
        if (en) begin
            mem[addr] <= wdata;
            rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/conv_deinterleaver.sv
module conv_deinterleaver #(
    parameter int MAX_DEPTH = 17,
    parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1),
    parameter int INCR_W    = 6,
    parameter int PTR_W     = 8,
    parameter int CNT_W     = 12,
    parameter int RAM_WORDS = 1122,
    parameter int DW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_cfg_load,
    input  logic [1:0]    i_cfg_sel,
    input  logic          i_valid,
    input  logic          i_start,
    input  logic [DW-1:0] i_data,
    output logic          o_valid,
    output logic          o_start,
    output logic [DW-1:0] o_data
);
    localparam int AW = $clog2(RAM_WORDS);

    typedef struct packed {
        logic [1:0]                      sel;
        logic                            running;
        logic [DEPTH_W-1:0]              branch;
        logic [MAX_DEPTH-1:0][PTR_W-1:0] ptrs;
        logic [CNT_W-1:0]                cnt;
        logic                            o_valid;
        logic                            o_start;
        logic                            byp_sel;
        logic [DW-1:0]                   byp;
    } st_t;

    st_t q, d;

    logic [DEPTH_W-1:0] depth_w;
    logic [INCR_W-1:0]  incr_w;
    logic [CNT_W-1:0]   lat_w;
    logic [DEPTH_W-1:0] cur_w;
    logic [DEPTH_W-1:0] branch_w;
    logic [PTR_W-1:0]   ptr_w;
    logic [PTR_W-1:0]   len_w;
    logic [AW-1:0]      addr_w;
    logic [DW-1:0]      rdata_w;
    logic               take_w;
    logic               ram_en_w;

    dil_cfg_decode #(.DEPTH_W(DEPTH_W), .INCR_W(INCR_W), .CNT_W(CNT_W)) cfg_i (
        .sel(q.sel), .depth(depth_w), .incr(incr_w), .latency(lat_w)
    );

    assign cur_w    = i_start ? '0 : q.branch;
    assign ptr_w    = q.ptrs[cur_w];
    assign branch_w = q.branch;
    assign take_w   = i_valid && (q.running || i_start) && !i_cfg_load;
    assign ram_en_w = take_w && (len_w != '0);

    dil_branch_addr #(.DEPTH_W(DEPTH_W), .INCR_W(INCR_W), .PTR_W(PTR_W), .AW(AW)) addr_i (
        .depth(depth_w), .incr(incr_w), .branch(cur_w), .ptr(ptr_w),
        .addr(addr_w), .len(len_w)
    );

    dil_ram #(.WORDS(RAM_WORDS), .AW(AW), .DW(DW)) ram_i (
        .clk(clk), .en(ram_en_w), .addr(addr_w), .wdata(i_data), .rdata(rdata_w)
    );

    always_comb begin
        d         = q;
        d.o_valid = 1'b0;
        d.o_start = 1'b0;
        if (i_cfg_load) begin
            d.sel     = i_cfg_sel;
            d.running = 1'b0;
            d.branch  = '0;
            d.ptrs    = '0;
            d.cnt     = '0;
        end else if (take_w) begin
            d.running = 1'b1;
            if (len_w != '0) begin
                d.ptrs[cur_w] = (ptr_w == len_w - PTR_W'(1)) ? '0 : ptr_w + PTR_W'(1);
            end
            d.branch  = (cur_w == depth_w - DEPTH_W'(1)) ? '0 : cur_w + DEPTH_W'(1);
            d.byp_sel = (len_w == '0);
            d.byp     = i_data;
            d.o_valid = (q.cnt >= lat_w);
            d.o_start = (q.cnt >= lat_w) && i_start;
            d.cnt     = (q.cnt >= lat_w) ? q.cnt : q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign o_valid = q.o_valid;
    assign o_start = q.o_start;
    assign o_data  = q.byp_sel ? q.byp : rdata_w;
endmodule

// File: rtl/conv_deinterleaver_chk.sv
module conv_deinterleaver_chk #(
    parameter int DEPTH_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               i_cfg_load,
    input logic               i_valid,
    input logic               i_start,
    input logic               o_valid,
    input logic               o_start,
    input logic [DEPTH_W-1:0] branch_w,
    input logic [DEPTH_W-1:0] depth_w
);
    // R7
    start_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_start |-> o_valid);

    // R7
    start_from_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_start |-> $past(i_start));

    // R6
    idle_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !i_valid |=> !o_valid);

    // R10
    load_drops_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        i_cfg_load |=> !o_valid);

    // R9
    branch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        branch_w < depth_w);
endmodule

bind conv_deinterleaver conv_deinterleaver_chk #(.DEPTH_W(DEPTH_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .i_cfg_load(i_cfg_load), .i_valid(i_valid),
    .i_start(i_start), .o_valid(o_valid), .o_start(o_start),
    .branch_w(branch_w), .depth_w(depth_w)
);

// File: tb/conv_deinterleaver_tb_top.sv
module conv_deinterleaver_tb_top;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       i_cfg_load = 1'b0;
    logic [1:0] i_cfg_sel = 2'd0;
    logic       i_valid = 1'b0;
    logic       i_start = 1'b0;
    logic [7:0] i_data = 8'd0;
    logic       o_valid;
    logic       o_start;
    logic [7:0] o_data;

    int n_tests = 0;
    int n_fail  = 0;
    int gap_ctr = 0;

    always #(PERIOD / 2) clk = ~clk;

    conv_deinterleaver dut_i (
        .clk(clk), .rst_n(rst_n), .i_cfg_load(i_cfg_load), .i_cfg_sel(i_cfg_sel),
        .i_valid(i_valid), .i_start(i_start), .i_data(i_data),
        .o_valid(o_valid), .o_start(o_start), .o_data(o_data)
    );

    function automatic logic [7:0] xf(input int n);
        int v;
        v = n * 29 + 7;
        return 8'(v ^ (v >>> 4));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock with the given inputs; outputs are sampled 1 time unit after the edge.
    task automatic cycle(input logic v, input logic s, input logic [7:0] b, input logic ld);
        @(negedge clk);
        i_valid    = v;
        i_start    = s;
        i_data     = b;
        i_cfg_load = ld;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_gap();
        gap_ctr++;
        if (gap_ctr % 9 == 0) begin
            cycle(1'b0, 1'b0, 8'hA5, 1'b0);
            check("R6 idle", int'(o_valid), 0);
        end
    endtask

    task automatic run_stream(input int dep, input int inc, input int seed, input bit full);
        int n, lat, j;
        n   = dep * inc;
        lat = n * (dep - 1);
        for (int t = 0; t < lat + 2 * n; t++) begin
            idle_gap();
            j = t % dep;
            cycle(1'b1, (t % n) == 0, xf(seed + t - j * dep * inc), 1'b0);
            if (t < lat) begin
                if (full) check("R5/R8 fill", int'(o_valid), 0);
            end else begin
                check("R5 valid", int'(o_valid), 1);
                check("R4 data", int'(o_data), int'(xf(seed + t - lat)));
                check("R7 start", int'(o_start), int'((t % n) == 0));
            end
        end
    endtask

    initial begin : watchdog
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int deps[4];
        int incs[4];
        deps = '{4, 6, 17, 12};
        incs = '{51, 34, 6, 17};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 valid", int'(o_valid), 0);
        check("R1 start", int'(o_start), 0);

        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            i_cfg_sel = 2'(s);
            // R10: byte with start presented together with the load is dropped
            cycle(1'b1, 1'b1, 8'h11, 1'b1);
            check("R10 load", int'(o_valid), 0);
            // R3: junk before any start is discarded
            for (int k = 0; k < 13; k++) begin
                cycle(1'b1, 1'b0, 8'(k * 7), 1'b0);
                check("R3 junk", int'(o_valid), 0);
            end
            // R2/R8: new setting, flushed branches
            run_stream(deps[s], incs[s], s * 1000, 1'b1);
        end

        // R9: off-phase bytes, then a start realigns branch rotation
        for (int k = 0; k < 5; k++) cycle(1'b1, 1'b0, 8'hEE, 1'b0);
        run_stream(deps[3], incs[3], 7777, 1'b0);

        cycle(1'b0, 1'b0, 8'h00, 1'b0);
        check("R6 end", int'(o_valid), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule